// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block models a small nonvolatile memory that answers as a slave on a two-wire serial bus. It holds 1024 bytes in four banks of 256. The bank is chosen by two bits of the addressing byte that opens each transfer. The design oversamples the bus clock and data lines with the system clock and finds START and STOP conditions and clock edges. It shifts bytes in and out, acknowledges what it accepts, and pulls the data line low through an open-drain output enable.

A master writes one byte, or a run of up to 16 bytes that wraps inside a 16-byte page. A write begins with an addressing byte followed by a one-byte word address. To read, the master either continues from the internal address counter, or first sets the counter with a write header and then issues a repeated START and a read header. Reads may go on for as many bytes as the master acknowledges. While the write-protect input is high, memory contents cannot change.

Top module: `twi_eeprom`

## Requirements
- R1: After reset the block leaves the data line released (`sda_oe_o` low).
- R2: An addressing byte whose upper nibble is 1010 (bits 7..4) is acknowledged by driving the data line low in the ninth clock. Any other nibble gets no acknowledge, and no further byte is acknowledged until the next START.
- R3: Bit 1 of the addressing byte has no effect. Bit 0 selects read (1) or write (0), and bits 3..2 select the 256-byte bank on a write.
- R4: A write header followed by a word-address byte and one data byte stores that data at address {bank bits, word address}. Every byte of this sequence is acknowledged.
- R5: During a multi-byte write, only the low four address bits advance after each data byte, and they wrap within the 16-byte page. A 17th byte overwrites the first byte written.
- R6: While `wp_i` is high, data bytes are still acknowledged but memory is left unchanged.
- R7: A write header and word address, then a repeated START and a read header, return the byte at the address that was set.
- R8: A read header that follows no word address returns the byte after the last one accessed. The bank bits of a read header are ignored.
- R9: A sequential read advances the full 10-bit address. It crosses bank boundaries and wraps from 0x3FF to 0x000.
- R10: When the master leaves a read byte unacknowledged (data high in the ninth clock), the slave stops driving the data line until the next START.
- R11: A STOP or START in the middle of a byte abandons it. A STOP releases the data line and stores nothing from the partial byte. A START begins a new addressing byte.
- R12: The slave changes its data-line drive only while the bus clock is low, following a falling clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| wp_i | input | 1 | Write protect, high blocks all memory updates |
| sda_oe_o | output | 1 | High pulls the data line low (open drain) |

## Verification
A corrupted bit counter or byte state shows within one byte time. The acknowledge lands in the wrong clock slot, or read data comes out shifted, and the bench's bit-level master catches it in the ninth clock of the transfer. A wrong address counter stays hidden until a later read. So every write is read back, across page wraps, bank crossings and the top-of-memory rollover. A data-line change while the clock is high would be seen by any master as a false START or STOP. The bench watches for it on every cycle.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

    parameter int DATA_W  = 8;
    parameter int BLK_W   = 2;
    parameter int WORD_W  = 8;
    parameter int PAGE_W  = 4;
    localparam int ADDR_W = BLK_W + WORD_W;
    localparam int DEPTH  = 1 << ADDR_W;

    // Addressing byte layout: device code on top, bank bits, spare bit, direction bit
    parameter logic [3:0] DEV_CODE = 4'b1010;
    localparam int CODE_LSB = DATA_W - 4;
    localparam int BLK_LSB  = CODE_LSB - BLK_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_WADDR,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } link_st_e;

    typedef enum logic [1:0] {
        AK_HDR_WR,
        AK_HDR_RD,
        AK_WORD,
        AK_DATA
    } ack_kind_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
        logic wp;
    } bus_ev_t;

    function automatic addr_t page_step(input addr_t a);
        addr_t r;
        r = a;
        r[PAGE_W-1:0] = a[PAGE_W-1:0] + 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/twi_eeprom_sense.sv
module twi_eeprom_sense
    import twi_eeprom_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    input  logic    wp_i,
    output bus_ev_t ev
);

    localparam int LINES = 3;
    localparam logic [LINES-1:0] IDLE_LVL = 3'b011;  // {wp, sda, scl}

    logic [SYNC_STAGES-1:0][LINES-1:0] chain;
    logic [LINES-1:0] now_q;
    logic [LINES-1:0] prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= IDLE_LVL;
                else     chain <= {wp_i, sda_i, scl_i};
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= {SYNC_STAGES{IDLE_LVL}};
                else     chain <= {chain[SYNC_STAGES-2:0], {wp_i, sda_i, scl_i}};
            end
        end
    endgenerate

    assign now_q = chain[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= IDLE_LVL;
        else     prev_q <= now_q;
    end

    always_comb begin
        ev.scl_rise = now_q[0] & ~prev_q[0];
        ev.scl_fall = ~now_q[0] & prev_q[0];
        ev.start    = now_q[0] & prev_q[0] & prev_q[1] & ~now_q[1];
        ev.stop     = now_q[0] & prev_q[0] & ~prev_q[1] & now_q[1];
        ev.sda      = now_q[1];
        ev.wp       = now_q[2];
    end

endmodule

// File: rtl/twi_eeprom_store.sv
module twi_eeprom_store
    import twi_eeprom_pkg::*;
(
    input  logic  clk,
    input  logic  we,
    input  addr_t waddr,
    input  byte_t wdata,
    input  addr_t raddr,
    output byte_t rdata
);

    byte_t cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/twi_eeprom_ctl.sv
module twi_eeprom_ctl
    import twi_eeprom_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    input  byte_t   rd_data,
    output logic    we,
    output addr_t   addr,
    output byte_t   wr_data,
    output logic    sda_oe
);

    localparam logic [3:0] BITS = 4'(DATA_W);

    link_st_e        st;
    ack_kind_e       kind;
    logic [3:0]      cnt;
    byte_t           sh;
    byte_t           tx;
    logic [BLK_W-1:0] blk;
    logic            more;
    addr_t           addr_q;
    logic            byte_done;
    logic            rx_state;

    assign byte_done = ev.scl_fall && (cnt == BITS);
    assign rx_state  = (st == ST_CTRL) || (st == ST_WADDR) || (st == ST_WDATA);
    assign we        = (st == ST_WDATA) && byte_done && !ev.wp;
    assign wr_data   = sh;
    assign addr      = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            kind   <= AK_HDR_WR;
            cnt    <= '0;
            sh     <= '0;
            tx     <= '0;
            blk    <= '0;
            more   <= 1'b0;
            addr_q <= '0;
            sda_oe <= 1'b0;
        end else if (ev.start) begin
            st     <= ST_CTRL;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (rx_state) begin
            if (ev.scl_rise && cnt != BITS) begin
                sh  <= {sh[DATA_W-2:0], ev.sda};
                cnt <= cnt + 4'd1;
            end else if (byte_done) begin
                cnt    <= '0;
                sda_oe <= 1'b1;
                st     <= ST_ACK;
                case (st)
                    ST_CTRL: begin
                        if (sh[DATA_W-1:CODE_LSB] == DEV_CODE) begin
                            blk  <= sh[BLK_LSB +: BLK_W];
                            kind <= sh[0] ? AK_HDR_RD : AK_HDR_WR;
                        end else begin
                            sda_oe <= 1'b0;
                            st     <= ST_IDLE;
                        end
                    end
                    ST_WADDR: begin
                        addr_q <= {blk, sh[WORD_W-1:0]};
                        kind   <= AK_WORD;
                    end
                    default: begin
                        addr_q <= page_step(addr_q);
                        kind   <= AK_DATA;
                    end
                endcase
            end
        end else begin
            case (st)
                ST_ACK: begin
                    if (ev.scl_fall) begin
                        if (kind == AK_HDR_RD) begin
                            tx     <= rd_data;
                            sda_oe <= ~rd_data[DATA_W-1];
                            cnt    <= 4'd1;
                            st     <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            st     <= (kind == AK_HDR_WR) ? ST_WADDR : ST_WDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    if (ev.scl_fall) begin
                        if (cnt == BITS) begin
                            sda_oe <= 1'b0;
                            more   <= 1'b0;
                            addr_q <= addr_q + 1'b1;
                            st     <= ST_RACK;
                        end else begin
                            tx     <= tx << 1;
                            sda_oe <= ~tx[DATA_W-2];
                            cnt    <= cnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (ev.scl_rise) begin
                        if (ev.sda) st <= ST_WAIT;
                        else        more <= 1'b1;
                    end else if (ev.scl_fall && more) begin
                        more   <= 1'b0;
                        tx     <= rd_data;
                        sda_oe <= ~rd_data[DATA_W-1];
                        cnt    <= 4'd1;
                        st     <= ST_RDATA;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/twi_eeprom.sv
module twi_eeprom
    import twi_eeprom_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe_o
);

    bus_ev_t ev;
    logic    mem_we;
    addr_t   mem_addr;
    byte_t   mem_wdata;
    byte_t   mem_rdata;

    twi_eeprom_sense #(.SYNC_STAGES(SYNC_STAGES)) sense_i (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .wp_i  (wp_i),
        .ev    (ev)
    );

    twi_eeprom_ctl ctl_i (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .rd_data (mem_rdata),
        .we      (mem_we),
        .addr    (mem_addr),
        .wr_data (mem_wdata),
        .sda_oe  (sda_oe_o)
    );

    twi_eeprom_store store_i (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_addr),
        .wdata (mem_wdata),
        .raddr (mem_addr),
        .rdata (mem_rdata)
    );

endmodule

// File: rtl/twi_eeprom_chk.sv
module twi_eeprom_chk
    import twi_eeprom_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  start,
    input logic  stop,
    input logic  scl_fall,
    input logic  wp_s,
    input logic  we,
    input addr_t addr,
    input logic  sda_oe
);

    // R11: a STOP always leaves the data line released
    p_release_on_stop_r11: assert property (@(posedge clk) disable iff (rst)
        stop |=> !sda_oe);

    // R12: drive changes only follow a falling clock or a bus condition
    p_drive_on_fall_r12: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(start) || $past(stop)));

    // R6: no store while protection is asserted
    p_wp_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        we |-> !wp_s);

    // R5: a stored byte advances only the in-page bits
    p_page_low_step_r5: assert property (@(posedge clk) disable iff (rst)
        we |=> (addr[PAGE_W-1:0] == PAGE_W'($past(addr[PAGE_W-1:0]) + 1'b1)));

    p_page_high_hold_r5: assert property (@(posedge clk) disable iff (rst)
        we |=> (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W])));

endmodule

bind twi_eeprom twi_eeprom_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .start    (ev.start),
    .stop     (ev.stop),
    .scl_fall (ev.scl_fall),
    .wp_s     (ev.wp),
    .we       (mem_we),
    .addr     (mem_addr),
    .sda_oe   (sda_oe_o)
);

// File: tb/twi_eeprom_tb_top.sv
module twi_eeprom_tb_top;

    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    int glitches = 0;
    logic prev_oe = 1'b0;

    logic [7:0] wbuf [20];
    logic [7:0] rbuf [20];

    always #10 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    twi_eeprom dut_i (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .wp_i     (wp),
        .sda_oe_o (sda_oe)
    );

    // R12 monitor: drive must never change while the clock is high
    always @(negedge clk) begin
        if (!rst && sda_oe != prev_oe && scl) glitches++;
        prev_oe = sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        m_sda = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b;  tick(Q);
        scl = 1'b1; tick(2*Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        b = sda_line; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic nak);
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(nak);
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic nak);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(nak);
    endtask

    task automatic set_ptr(input logic [9:0] a, input string req);
        logic k;
        bus_start;
        send_byte({4'hA, a[9:8], 2'b00}, k);
        chk({req, " header ack"}, k, 0);
        send_byte(a[7:0], k);
        chk({req, " word ack"}, k, 0);
    endtask

    task automatic write_run(input logic [9:0] a, input int n, input string req);
        logic k;
        set_ptr(a, req);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], k);
            chk({req, " data ack"}, k, 0);
        end
        bus_stop;
    endtask

    task automatic read_cur(input logic [7:0] hdr, input int n, input string req);
        logic k;
        bus_start;
        send_byte(hdr, k);
        chk({req, " read header ack"}, k, 0);
        for (int i = 0; i < n; i++) recv_byte(rbuf[i], (i == n - 1));
    endtask

    task automatic read_at(input logic [9:0] a, input int n, input string req);
        set_ptr(a, req);
        read_cur(8'hA1, n, req);
        bus_stop;
    endtask

    task automatic t_reset;
        chk("R1 oe after reset", sda_oe, 0);
        tick(20);
        chk("R1 oe idle", sda_oe, 0);
    endtask

    task automatic t_byte_write;
        logic b;
        int ones;
        wbuf[0] = 8'hA5;
        write_run(10'h125, 1, "R4");
        set_ptr(10'h125, "R7");
        read_cur(8'hA1, 1, "R7");
        chk("R7 random read data", rbuf[0], 8'hA5);
        chk("R4 stored byte", rbuf[0], 8'hA5);
        ones = 0;
        for (int i = 0; i < 9; i++) begin
            get_bit(b);
            ones += b;
        end
        chk("R10 released after nack", ones, 9);
        bus_stop;
    endtask

    task automatic t_spare_bit;
        logic k;
        bus_start;
        send_byte(8'hA2 | 8'h04, k);
        chk("R3 header with spare bit ack", k, 0);
        send_byte(8'h26, k);
        chk("R3 word ack", k, 0);
        send_byte(8'h3C, k);
        chk("R3 data ack", k, 0);
        bus_stop;
        read_at(10'h126, 1, "R3");
        chk("R3 data stored at bank 1", rbuf[0], 8'h3C);
    endtask

    task automatic t_bad_header;
        logic k;
        bus_start;
        send_byte(8'hB0, k);
        chk("R2 foreign header no ack", k, 1);
        send_byte(8'h10, k);
        chk("R2 follow byte no ack", k, 1);
        bus_stop;
    endtask

    task automatic t_page_wrap;
        logic [7:0] exp;
        wbuf[0] = 8'h77;
        write_run(10'h300, 1, "R5");
        for (int i = 0; i < 17; i++) wbuf[i] = 8'(8'h40 + i);
        write_run(10'h2F8, 17, "R5");
        read_at(10'h2F0, 16, "R5");
        for (int j = 0; j < 16; j++) begin
            if (j == 8)     exp = 8'h50;
            else if (j > 8) exp = 8'(8'h40 + j - 8);
            else            exp = 8'(8'h48 + j);
            chk("R5 page content", rbuf[j], exp);
        end
        read_at(10'h300, 1, "R5");
        chk("R5 next page untouched", rbuf[0], 8'h77);
    endtask

    task automatic t_protect;
        wp = 1'b1;
        wbuf[0] = 8'h00;
        wbuf[1] = 8'hFF;
        write_run(10'h125, 2, "R6");
        wp = 1'b0;
        read_at(10'h125, 1, "R6");
        chk("R6 protected byte kept", rbuf[0], 8'hA5);
    endtask

    task automatic t_current;
        read_cur(8'hA7, 1, "R8");
        bus_stop;
        chk("R8 current address byte", rbuf[0], 8'h3C);
    endtask

    task automatic t_rollover;
        wbuf[0] = 8'h99; write_run(10'h3FF, 1, "R9");
        wbuf[0] = 8'h11; write_run(10'h000, 1, "R9");
        wbuf[0] = 8'h22; write_run(10'h0FF, 1, "R9");
        wbuf[0] = 8'h33; write_run(10'h100, 1, "R9");
        read_at(10'h3FF, 2, "R9");
        chk("R9 top byte", rbuf[0], 8'h99);
        chk("R9 wrap to zero", rbuf[1], 8'h11);
        read_at(10'h0FF, 2, "R9");
        chk("R9 bank end", rbuf[0], 8'h22);
        chk("R9 bank crossing", rbuf[1], 8'h33);
    endtask

    task automatic t_abort;
        logic k;
        set_ptr(10'h000, "R11");
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_stop;
        chk("R11 released after stop", sda_oe, 0);
        read_at(10'h000, 1, "R11");
        chk("R11 partial byte not stored", rbuf[0], 8'h11);
        set_ptr(10'h000, "R11");
        for (int i = 0; i < 3; i++) put_bit(1'b0);
        bus_start;
        send_byte(8'hA0, k);
        chk("R11 start resyncs header", k, 0);
        send_byte(8'h01, k);
        chk("R11 word ack", k, 0);
        send_byte(8'h5A, k);
        chk("R11 data ack", k, 0);
        bus_stop;
        read_at(10'h000, 2, "R11");
        chk("R11 byte 0 intact", rbuf[0], 8'h11);
        chk("R11 new byte stored", rbuf[1], 8'h5A);
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(2);
        t_reset;
        t_byte_write;
        t_spare_bit;
        t_bad_header;
        t_page_wrap;
        t_protect;
        t_current;
        t_rollover;
        t_abort;
        chk("R12 no drive change with clock high", glitches, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule